// File: doc/BRIEF.md
# Configuration Upset Sensitivity Scorer

This block grades a configuration for a small reconfigurable combinational circuit. Once started, it feeds every input combination to the circuit under evaluation with the configuration unchanged and counts how many output bits agree with a golden truth table. That count is the correctness score. It then walks the configuration one bit at a time. For each bit it presents the configuration with only that bit inverted, sweeps the input combinations again, and records whether any output differs from the golden table. The number of such harmful bits is the sensitivity count.

The two results are folded into one fitness value, score × WEIGHT + (CFG_W − sensitivity). Correctness therefore always outranks robustness when WEIGHT is larger than CFG_W. A search engine outside the block supplies the configuration and the truth table, pulses start, and reads the three results once done is high. The circuit under evaluation sits outside, between the block's stimulus outputs (`dut_cfg`, `dut_in`) and its response input (`dut_out`). It must settle within the cycle in which it is driven.

Top module: `cfg_upset_scorer`

## Requirements
- R1: After reset, busy and done are low, score and sens_cnt are zero, and dut_cfg equals cfg_word.
- R2: score is the number of output bits j and vectors v for which dut_out[j] equals golden[v*OUT_W + j] while dut_in = v and dut_cfg = cfg_word, summed over all 2^IN_W vectors (16 for a 3-input, 2-output circuit whose response matches).
- R3: sens_cnt is the number of configuration bits whose inversion alone produces at least one output bit that differs from the golden table during a sweep of all vectors.
- R4: During the fault sweep dut_cfg differs from cfg_word in exactly one bit, the inverted bit position never decreases, and every position 0 to CFG_W−1 is tried. Outside the fault sweep dut_cfg equals cfg_word.
- R5: fitness equals score × WEIGHT + CFG_W − sens_cnt (with defaults, score × 100 + 74 − sens_cnt).
- R6: The block spends exactly one cycle per compared vector. The baseline pass takes 2^IN_W cycles. With early stop enabled, a bit's sweep ends in the cycle of its first mismatch, so it takes (index of the first failing vector + 1) cycles, or 2^IN_W cycles if no vector fails.
- R7: A start pulse seen while idle or done begins a run. busy stays high for the whole run. done then stays high, with the results held, until the next start. A start pulse while busy is ignored.
- R8: The count reaches both extremes: 0 when no single inversion changes any output, and CFG_W when every inversion is harmful, including the case where the baseline already mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken when not busy) |
| cfg_word | input | CFG_W | Configuration under test, held during a run |
| golden | input | 2^IN_W × OUT_W | Expected response, vector v at bits v*OUT_W upward |
| dut_cfg | output | CFG_W | Configuration driven to the circuit, possibly with one bit inverted |
| dut_in | output | IN_W | Input vector driven to the circuit |
| dut_out | input | OUT_W | Combinational response of the circuit |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid |
| score | output | clog2(2^IN_W × OUT_W + 1) | Baseline correctness score |
| sens_cnt | output | clog2(CFG_W + 1) | Number of harmful bit inversions |
| fitness | output | clog2(score max × WEIGHT + CFG_W + 1) | Combined fitness |

## Verification
The assertions assume that cfg_word and golden do not change while busy is high. They also assume that dut_out is a function of the current dut_cfg and dut_in alone. The one-hot difference and sweep-order properties compare dut_cfg against a cfg_word that is held in this way. The bench changes the configuration, the truth table and the model's variant only at a falling edge after done has been seen. Its circuit model is a pure function evaluated through a continuous assignment, so the response follows the stimulus within the same cycle.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_BASE = 2'd1,
      PH_FLIP = 2'd2,
      PH_DONE = 2'd3
   } fsa_phase_e;
endpackage

// File: rtl/fsa_vec_ctr.sv
module fsa_vec_ctr #(
   parameter int IN_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            adv,
   output logic [IN_W-1:0] vec,
   output logic            last
);
   logic [IN_W-1:0] vec_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      vec_q <= '0;
      else if (clr)    vec_q <= '0;
      else if (adv)    vec_q <= vec_q + IN_W'(1);
   end

   assign vec  = vec_q;
   assign last = &vec_q;
endmodule

// File: rtl/fsa_bit_walker.sv
module fsa_bit_walker #(
   parameter int CFG_W = 74,
   parameter int BIT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             inject,
   input  logic [CFG_W-1:0] cfg_in,
   output logic [CFG_W-1:0] cfg_out,
   output logic             last
);
   logic [BIT_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (clr)    idx_q <= '0;
      else if (step)   idx_q <= idx_q + BIT_W'(1);
   end

   for (genvar k = 0; k < CFG_W; k++) begin : g_flip
      assign cfg_out[k] = cfg_in[k] ^ (inject && (idx_q == BIT_W'(k)));
   end

   assign last = (idx_q == BIT_W'(CFG_W - 1));

   // R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q < BIT_W'(CFG_W));
endmodule

// File: rtl/fsa_match.sv
module fsa_match #(
   parameter int IN_W  = 3,
   parameter int OUT_W = 2,
   parameter int HIT_W = 2
) (
   input  logic [IN_W-1:0]               vec,
   input  logic [(OUT_W << IN_W)-1:0]    golden,
   input  logic [OUT_W-1:0]              resp,
   output logic [HIT_W-1:0]              hits,
   output logic                          any_miss
);
   logic [OUT_W-1:0] want;
   logic [OUT_W-1:0] eq;

   assign want = golden[vec*OUT_W +: OUT_W];

   for (genvar j = 0; j < OUT_W; j++) begin : g_eq
      assign eq[j] = ~(resp[j] ^ want[j]);
   end

   assign hits     = HIT_W'($countones(eq));
   assign any_miss = ~&eq;
endmodule

// File: rtl/cfg_upset_scorer.sv
module cfg_upset_scorer
   import fsa_pkg::*;
#(
   parameter int CFG_W      = 74,
   parameter int IN_W       = 3,
   parameter int OUT_W      = 2,
   parameter int WEIGHT     = 100,
   parameter bit EARLY_STOP = 1'b1,
   localparam int VEC_N     = 1 << IN_W,
   localparam int GOLD_W    = VEC_N * OUT_W,
   localparam int SCORE_W   = $clog2(GOLD_W + 1),
   localparam int SENS_W    = $clog2(CFG_W + 1),
   localparam int FIT_W     = $clog2(GOLD_W * WEIGHT + CFG_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CFG_W-1:0]   cfg_word,
   input  logic [GOLD_W-1:0]  golden,
   output logic [CFG_W-1:0]   dut_cfg,
   output logic [IN_W-1:0]    dut_in,
   input  logic [OUT_W-1:0]   dut_out,
   output logic               busy,
   output logic               done,
   output logic [SCORE_W-1:0] score,
   output logic [SENS_W-1:0]  sens_cnt,
   output logic [FIT_W-1:0]   fitness
);
   localparam int BIT_W = (CFG_W > 2) ? $clog2(CFG_W) : 1;
   localparam int HIT_W = $clog2(OUT_W + 1);

   if (IN_W < 1 || OUT_W < 1 || CFG_W < 2 || WEIGHT < 1) begin : g_bad_cfg
      $error("cfg_upset_scorer: parameter out of range");
   end

   fsa_phase_e         phase_q;
   logic [SCORE_W-1:0] score_q;
   logic [SENS_W-1:0]  sens_q;
   logic               hit_q;
   logic               start_ok, vec_last, bit_last, bit_end, stop_now, any_miss;
   logic [HIT_W-1:0]   hits;

   assign busy     = (phase_q == PH_BASE) || (phase_q == PH_FLIP);
   assign done     = (phase_q == PH_DONE);
   assign start_ok = start && !busy;

   if (EARLY_STOP) begin : g_early
      assign stop_now = any_miss;
   end else begin : g_full
      assign stop_now = 1'b0;
   end

   assign bit_end = (phase_q == PH_FLIP) && (vec_last || stop_now);

   fsa_vec_ctr #(.IN_W(IN_W)) u_vec (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok || bit_end),
      .adv   (busy),
      .vec   (dut_in),
      .last  (vec_last)
   );

   fsa_bit_walker #(.CFG_W(CFG_W), .BIT_W(BIT_W)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_ok),
      .step    (bit_end && !bit_last),
      .inject  (phase_q == PH_FLIP),
      .cfg_in  (cfg_word),
      .cfg_out (dut_cfg),
      .last    (bit_last)
   );

   fsa_match #(.IN_W(IN_W), .OUT_W(OUT_W), .HIT_W(HIT_W)) u_match (
      .vec      (dut_in),
      .golden   (golden),
      .resp     (dut_out),
      .hits     (hits),
      .any_miss (any_miss)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         score_q <= '0;
         sens_q  <= '0;
         hit_q   <= 1'b0;
      end else begin
         case (phase_q)
            PH_BASE: begin
               score_q <= score_q + SCORE_W'(hits);
               if (vec_last) phase_q <= PH_FLIP;
            end
            PH_FLIP: begin
               if (bit_end) begin
                  hit_q <= 1'b0;
                  if (any_miss || hit_q) sens_q <= sens_q + SENS_W'(1);
                  if (bit_last) phase_q <= PH_DONE;
               end else if (any_miss) begin
                  hit_q <= 1'b1;
               end
            end
            default: begin
               if (start) begin
                  phase_q <= PH_BASE;
                  score_q <= '0;
                  sens_q  <= '0;
                  hit_q   <= 1'b0;
               end
            end
         endcase
      end
   end

   assign score    = score_q;
   assign sens_cnt = sens_q;
   assign fitness  = FIT_W'(score_q) * FIT_W'(WEIGHT) + FIT_W'(CFG_W) - FIT_W'(sens_q);

   // R2
   score_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      score_q <= SCORE_W'(GOLD_W));
   // R3
   sens_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sens_q <= SENS_W'(CFG_W));
   // R3
   sens_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (sens_q == $past(sens_q)) || (sens_q == $past(sens_q) + SENS_W'(1)));
   // R4
   flip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FLIP) |-> ($countones(dut_cfg ^ cfg_word) == 1));
   // R4
   base_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_FLIP) |-> (dut_cfg == cfg_word));
   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(score_q) && $stable(sens_q)));
   // R7
   input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(cfg_word) && $stable(golden)));
endmodule

// File: tb/cfg_upset_scorer_tb.sv
module cfg_upset_scorer_tb_top;
   localparam int CFG_W  = 74;
   localparam int IN_W   = 3;
   localparam int OUT_W  = 2;
   localparam int WEIGHT = 100;
   localparam int VEC_N  = 1 << IN_W;
   localparam int GOLD_W = VEC_N * OUT_W;
   localparam int SCORE_W = $clog2(GOLD_W + 1);
   localparam int SENS_W  = $clog2(CFG_W + 1);
   localparam int FIT_W   = $clog2(GOLD_W * WEIGHT + CFG_W + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CFG_W-1:0]   cfg_w = '0;
   logic [GOLD_W-1:0]  gold_w = '0;
   logic [CFG_W-1:0]   dut_cfg;
   logic [IN_W-1:0]    dut_in;
   logic [OUT_W-1:0]   dut_out;
   logic busy, done;
   logic [SCORE_W-1:0] score;
   logic [SENS_W-1:0]  sens_cnt;
   logic [FIT_W-1:0]   fitness;
   int mode_r = 0;
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   // Model of the circuit under evaluation.
   // mode 0: two 8-entry lookup columns (bits 0..15), inverted when bits 16 and 17 are both set.
   // mode 1: lookup columns inverted by the parity of bits 16..73 (every bit matters).
   // mode 2: a fixed full adder that ignores the configuration.
   function automatic logic [1:0] dev_eval(int md, logic [CFG_W-1:0] c, logic [IN_W-1:0] v);
      logic [1:0] lut;
      lut = {c[8 + int'(v)], c[int'(v)]};
      case (md)
         0: return lut ^ {2{c[16] & c[17]}};
         1: return lut ^ {2{^c[CFG_W-1:16]}};
         default: return {(v[0] & v[1]) | (v[2] & (v[0] ^ v[1])), ^v};
      endcase
   endfunction

   assign dut_out = dev_eval(mode_r, dut_cfg, dut_in);

   cfg_upset_scorer dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_w), .golden(gold_w),
      .dut_cfg(dut_cfg), .dut_in(dut_in), .dut_out(dut_out), .busy(busy), .done(done),
      .score(score), .sens_cnt(sens_cnt), .fitness(fitness)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [GOLD_W-1:0] table_of(int md, logic [CFG_W-1:0] c);
      logic [GOLD_W-1:0] t;
      for (int v = 0; v < VEC_N; v++) t[v*OUT_W +: OUT_W] = dev_eval(md, c, IN_W'(v));
      return t;
   endfunction

   task automatic ref_run(input int md, input logic [CFG_W-1:0] c, input logic [GOLD_W-1:0] g,
                          output int sc, output int sn, output int cy);
      sc = 0; sn = 0; cy = VEC_N;
      for (int v = 0; v < VEC_N; v++) begin
         logic [1:0] r;
         r = dev_eval(md, c, IN_W'(v));
         for (int j = 0; j < OUT_W; j++) if (r[j] == g[v*OUT_W + j]) sc++;
      end
      for (int b = 0; b < CFG_W; b++) begin
         logic [CFG_W-1:0] f;
         int hit;
         f = c ^ (CFG_W'(1) << b);
         hit = -1;
         for (int v = 0; v < VEC_N; v++)
            if (hit < 0 && dev_eval(md, f, IN_W'(v)) != g[v*OUT_W +: OUT_W]) hit = v;
         if (hit >= 0) begin sn++; cy += hit + 1; end
         else cy += VEC_N;
      end
   endtask

   int last_sc, last_sn;

   task automatic run_case(input int md, input logic [CFG_W-1:0] c, input logic [GOLD_W-1:0] g,
                           input bit glitch);
      int sc, sn, cy, cyc, last_idx, seen, held_sc;
      bit order_ok;
      mode_r = md; cfg_w = c; gold_w = g;
      ref_run(md, c, g, sc, sn, cy);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0; last_idx = -1; seen = 0; order_ok = 1'b1;
      while (!done && cyc < 2000) begin
         if (busy) begin
            logic [CFG_W-1:0] d;
            cyc++;
            d = dut_cfg ^ cfg_w;
            if ($countones(d) > 1) order_ok = 1'b0;
            else if ($countones(d) == 1) begin
               for (int k = 0; k < CFG_W; k++) if (d[k]) begin
                  if (k < last_idx) order_ok = 1'b0;
                  if (k != last_idx) seen++;
                  last_idx = k;
               end
            end
         end
         start = (glitch && cyc == 5);
         @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1, "R7 watchdog/done", done, 1);
      chk(score == SCORE_W'(sc), "R2 score", score, sc);
      chk(sens_cnt == SENS_W'(sn), "R3 sens_cnt", sens_cnt, sn);
      chk(fitness == FIT_W'(sc * WEIGHT + CFG_W - sn), "R5 fitness", fitness, sc * WEIGHT + CFG_W - sn);
      chk(cyc == cy, "R6 cycle count", cyc, cy);
      chk(order_ok && seen == CFG_W, "R4 flip walk", seen, CFG_W);
      chk(dut_cfg == cfg_w, "R4 clean after run", $countones(dut_cfg ^ cfg_w), 0);
      held_sc = int'(score);
      repeat (3) @(negedge clk);
      chk(done && !busy && int'(score) == held_sc, "R7 done holds", done, 1);
      last_sc = sc; last_sn = sn;
   endtask

   function automatic logic [CFG_W-1:0] rnd_cfg();
      return {$urandom, $urandom, $urandom};
   endfunction

   initial begin
      void'($urandom(32'h5EED_0042));
      cfg_w = 74'h2_5A5A_0F0F_1234_5678_9A;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
      chk(score == 0 && sens_cnt == 0, "R1 counters", score + sens_cnt, 0);
      chk(dut_cfg == cfg_w, "R1 dut_cfg", $countones(dut_cfg ^ cfg_w), 0);

      // R2 R3 random configurations and tables
      for (int i = 0; i < 4; i++) run_case(0, rnd_cfg(), GOLD_W'($urandom), 1'b0);
      // R2 matched table gives full score
      begin
         logic [CFG_W-1:0] c;
         c = rnd_cfg();
         run_case(0, c, table_of(0, c), 1'b0);
         chk(last_sc == GOLD_W, "R2 full score", score, GOLD_W);
         c[17:16] = 2'b11;
         run_case(0, c, table_of(0, c), 1'b0);
      end
      // R8 every bit harmful
      begin
         logic [CFG_W-1:0] c;
         c = rnd_cfg();
         run_case(1, c, table_of(1, c), 1'b0);
         chk(sens_cnt == SENS_W'(CFG_W), "R8 all harmful", sens_cnt, CFG_W);
         chk(fitness == FIT_W'(GOLD_W * WEIGHT), "R8 fitness all harmful", fitness, GOLD_W * WEIGHT);
      end
      // R8 no bit harmful
      run_case(2, rnd_cfg(), table_of(2, '0), 1'b0);
      chk(sens_cnt == 0, "R8 none harmful", sens_cnt, 0);
      chk(fitness == FIT_W'(GOLD_W * WEIGHT + CFG_W), "R8 fitness none harmful", fitness, GOLD_W * WEIGHT + CFG_W);
      // R8 baseline already wrong: every inversion counts, zero score
      run_case(2, rnd_cfg(), ~table_of(2, '0), 1'b0);
      chk(sens_cnt == SENS_W'(CFG_W) && score == 0, "R8 broken baseline", sens_cnt, CFG_W);
      chk(fitness == 0, "R8 fitness floor", fitness, 0);
      // R7 start while busy ignored
      run_case(0, rnd_cfg(), GOLD_W'($urandom), 1'b1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule